// File: doc/BRIEF.md
# Path Parity Byte Generator with Error Injection

This block produces the byte that fills the path parity (B3) slot of an outgoing frame. When it computes the byte itself, it forms an 8-bit bit-interleaved parity. Each of the eight bit lanes holds the XOR of the same bit position across every byte marked as payload during one frame. The result from one frame is carried into the parity slot of the frame that follows. Instead of the computed value, the slot can carry a value set by the host, the byte present on the parallel input bus, or a byte from the serial overhead input.

For test purposes, the selected byte can be inverted in all eight bits. A one-shot request corrupts exactly one slot and then clears itself. A hold setting corrupts every slot for as long as it stays set. A frame-start pulse marks where each frame begins. A slot strobe marks the cycle in which the parity byte is emitted. The output is registered and appears one cycle after the strobe, together with a valid flag.

Top module: `path_bip_gen`

## Requirements
- R1: With `src_sel_i` = 0 (host), the byte emitted for a slot equals `host_b3_i` sampled in the slot cycle, when no inversion is active.
- R2: With `src_sel_i` = 1 (bus), the emitted byte equals `data_i` sampled in the slot cycle.
- R3: With `src_sel_i` = 2 (overhead input), the emitted byte equals `ovh_b3_i` sampled in the slot cycle.
- R4: With `src_sel_i` = 3 (calculated), the emitted byte is the bitwise XOR of every `data_i` byte with `pay_en_i` high in the previous frame. A frame runs from a `frame_i` cycle, inclusive, up to the next `frame_i` cycle, exclusive.
- R5: Bytes with `pay_en_i` low do not change the calculated parity.
- R6: After reset, the calculated parity reads 0x00 until a complete frame has been accumulated, which means until the second `frame_i` pulse.
- R7: A one-cycle `inv_once_i` request inverts all eight bits of the byte in the first slot strictly after the request cycle, and of no later slot. A request made in a slot cycle applies to the next slot.
- R8: While `inv_hold_i` is high in a slot cycle, the emitted byte is inverted. Once it is low, slots are no longer inverted.
- R9: Inversion is applied after source selection, whatever the source.
- R10: `b3_vld_o` is high exactly one cycle after each `slot_i` cycle. `b3_o` keeps its value between slots.
- R11: During reset, `b3_o` is 0x00 and `b3_vld_o` is low.
- R12: A one-shot request served while hold is also active inverts that byte only once, and the request is consumed by that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Byte stream; parity input and bus source |
| pay_en_i | input | 1 | Marks the current byte as payload covered by parity |
| slot_i | input | 1 | Parity byte slot strobe |
| frame_i | input | 1 | Frame-start pulse |
| src_sel_i | input | 2 | Source select: 0 host, 1 bus, 2 overhead, 3 calculated |
| host_b3_i | input | 8 | Host-programmed parity value |
| ovh_b3_i | input | 8 | Byte from the serial overhead input |
| inv_once_i | input | 1 | One-shot request to invert the next slot |
| inv_hold_i | input | 1 | Continuous inversion while high |
| b3_o | output | 8 | Emitted parity slot byte |
| b3_vld_o | output | 1 | High in the cycle that `b3_o` is refreshed |

## Verification
A wrong accumulator lane or a bad frame-boundary latch does not show up during the frame where the error happens. It appears at the slot of the next frame, as a wrong calculated byte, so checks compare each slot against the parity of the frame before it. A stuck or leaking one-shot flag shows up at the first slot after the request, or at the slot after that, as inversion that is missing or repeated. A source-mux fault shows at the very next slot. The sequences therefore run three frames in a row per scenario, so that both the effect and its clearing can be seen.

// File: rtl/path_bip_pkg.sv
package path_bip_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_OVH  = 2'd2,
    SRC_CALC = 2'd3
  } b3_src_e;
endpackage

// File: rtl/bip_accum.sv
module bip_accum #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         pay_en_i,
  input  logic         frame_i,
  output logic [W-1:0] par_o
);
  logic         run_q;
  logic [W-1:0] acc_q, par_q;

  // run_q blocks a partial first frame from being latched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (frame_i) run_q <= 1'b1;
  end

  for (genvar b = 0; b < W; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[b] <= 1'b0;
        par_q[b] <= 1'b0;
      end else if (frame_i) begin
        par_q[b] <= acc_q[b];
        acc_q[b] <= pay_en_i & data_i[b];
      end else if (run_q && pay_en_i) begin
        acc_q[b] <= acc_q[b] ^ data_i[b];
      end
    end
  end

  assign par_o = par_q;
endmodule

// File: rtl/bip_src_mux.sv
module bip_src_mux
  import path_bip_pkg::*;
#(
  parameter int W = 8
) (
  input  b3_src_e      src_i,
  input  logic [W-1:0] host_i,
  input  logic [W-1:0] bus_i,
  input  logic [W-1:0] ovh_i,
  input  logic [W-1:0] calc_i,
  output logic [W-1:0] sel_o
);
  always_comb begin
    unique case (src_i)
      SRC_HOST: sel_o = host_i;
      SRC_BUS:  sel_o = bus_i;
      SRC_OVH:  sel_o = ovh_i;
      default:  sel_o = calc_i;
    endcase
  end
endmodule

// File: rtl/bip_inject.sv
module bip_inject #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slot_i,
  input  logic [W-1:0] sel_i,
  input  logic         once_i,
  input  logic         hold_i,
  output logic [W-1:0] b3_o,
  output logic         vld_o
);
  logic         pend_q;
  logic [W-1:0] mask;
  logic [W-1:0] b3_q;
  logic         vld_q;

  // a request seen in a slot cycle is kept for the following slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (slot_i) pend_q <= once_i;
    else if (once_i) pend_q <= 1'b1;
  end

  assign mask = (pend_q || hold_i) ? {W{1'b1}} : {W{1'b0}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b3_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= slot_i;
      if (slot_i) b3_q <= sel_i ^ mask;
    end
  end

  assign b3_o  = b3_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/path_bip_gen.sv
module path_bip_gen
  import path_bip_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         pay_en_i,
  input  logic         slot_i,
  input  logic         frame_i,
  input  logic [1:0]   src_sel_i,
  input  logic [W-1:0] host_b3_i,
  input  logic [W-1:0] ovh_b3_i,
  input  logic         inv_once_i,
  input  logic         inv_hold_i,
  output logic [W-1:0] b3_o,
  output logic         b3_vld_o
);
  logic [W-1:0] calc_par;
  logic [W-1:0] sel_byte;
  b3_src_e      src;

  assign src = b3_src_e'(src_sel_i);

  bip_accum #(.W(W)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .pay_en_i (pay_en_i),
    .frame_i  (frame_i),
    .par_o    (calc_par)
  );

  bip_src_mux #(.W(W)) u_mux (
    .src_i  (src),
    .host_i (host_b3_i),
    .bus_i  (data_i),
    .ovh_i  (ovh_b3_i),
    .calc_i (calc_par),
    .sel_o  (sel_byte)
  );

  bip_inject #(.W(W)) u_inject (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (slot_i),
    .sel_i  (sel_byte),
    .once_i (inv_once_i),
    .hold_i (inv_hold_i),
    .b3_o   (b3_o),
    .vld_o  (b3_vld_o)
  );
endmodule

// File: rtl/path_bip_gen_chk.sv
module path_bip_gen_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] data_i,
  input logic         slot_i,
  input logic [1:0]   src_sel_i,
  input logic [W-1:0] host_b3_i,
  input logic         inv_once_i,
  input logic         inv_hold_i,
  input logic [W-1:0] b3_o,
  input logic         b3_vld_o
);
  // independent tracker of an outstanding one-shot request
  logic req_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         req_q <= 1'b0;
    else if (slot_i)     req_q <= inv_once_i;
    else if (inv_once_i) req_q <= 1'b1;
  end

  // R10
  vld_after_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> b3_vld_o);
  // R10
  vld_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> !b3_vld_o);
  // R10
  b3_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(b3_o));
  // R1
  host_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && src_sel_i == 2'd0 && !inv_hold_i && !req_q) |=> b3_o == $past(host_b3_i));
  // R7
  host_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && src_sel_i == 2'd0 && req_q) |=> b3_o == ~$past(host_b3_i));
  // R8
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && src_sel_i == 2'd1 && inv_hold_i) |=> b3_o == ~$past(data_i));
  // R11
  always_comb begin
    if (!rst_ni) begin
      reset_out_chk: assert (b3_o == '0 && !b3_vld_o);
    end
  end
endmodule

bind path_bip_gen path_bip_gen_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .slot_i     (slot_i),
  .src_sel_i  (src_sel_i),
  .host_b3_i  (host_b3_i),
  .inv_once_i (inv_once_i),
  .inv_hold_i (inv_hold_i),
  .b3_o       (b3_o),
  .b3_vld_o   (b3_vld_o)
);

// File: tb/path_bip_gen_test.sv
module path_bip_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       pay = 1'b0, slot = 1'b0, frame = 1'b0;
  logic [1:0] src = 2'd0;
  logic [7:0] host = '0, ovh = '0;
  logic       once = 1'b0, hold = 1'b0;
  logic [7:0] b3;
  logic       vld;
  int n_chk = 0, n_fail = 0;
  logic [7:0] prev, p;

  always #10 clk = ~clk;

  path_bip_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .pay_en_i(pay),
    .slot_i(slot), .frame_i(frame), .src_sel_i(src), .host_b3_i(host),
    .ovh_b3_i(ovh), .inv_once_i(once), .inv_hold_i(hold),
    .b3_o(b3), .b3_vld_o(vld)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] d, input logic pe, input logic sl,
                      input logic fr, input logic on);
    data = d; pay = pe; slot = sl; frame = fr; once = on;
    @(negedge clk);
  endtask

  // one frame: pulse, slot, then payload with gaps; returns its parity
  task automatic run_frame(input logic [7:0] base, input int n, input logic [7:0] exp,
                           input logic once_at_slot, input string tag,
                           output logic [7:0] par);
    par = base;
    step(base, 1'b1, 1'b0, 1'b1, 1'b0);
    step(base ^ 8'h5A, 1'b0, 1'b1, 1'b0, once_at_slot);
    check(b3, exp, tag);
    check({7'd0, vld}, 8'd1, "R10 valid after slot");
    for (int i = 2; i < n; i++) begin
      logic [7:0] d;
      logic pe;
      d  = base + 8'(i * 37);
      pe = (i % 3) != 0;
      step(d, pe, 1'b0, 1'b0, 1'b0);
      if (pe) par = par ^ d;
      if (i == 2) begin
        check({7'd0, vld}, 8'd0, "R10 valid drops");
        check(b3, exp, "R10 byte held");
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(b3, 8'h00, "R11 byte in reset");
    check({7'd0, vld}, 8'd0, "R11 valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_calc();
    src = 2'd3;
    step(8'hE7, 1'b1, 1'b0, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    check(b3, 8'h00, "R6 before any frame");
    run_frame(8'h11, 9, 8'h00, 1'b0, "R6 first frame", p);
    prev = p;
    run_frame(8'h3C, 12, prev, 1'b0, "R4 R5 calc parity", p);
    prev = p;
    run_frame(8'hA5, 7, prev, 1'b0, "R4 calc parity 2", p);
    prev = p;
  endtask

  task automatic t_sources();
    src = 2'd0; host = 8'hC3;
    run_frame(8'h02, 5, 8'hC3, 1'b0, "R1 host source", p);
    src = 2'd1;
    run_frame(8'h47, 5, 8'h47 ^ 8'h5A, 1'b0, "R2 bus source", p);
    src = 2'd2; ovh = 8'h96;
    run_frame(8'h09, 5, 8'h96, 1'b0, "R3 overhead source", p);
    prev = p;
  endtask

  task automatic t_once();
    src = 2'd0; host = 8'h21;
    run_frame(8'h01, 6, 8'h21, 1'b1, "R7 request at slot not applied", p);
    run_frame(8'h02, 6, 8'hDE, 1'b0, "R7 next slot inverted", p);
    run_frame(8'h03, 6, 8'h21, 1'b0, "R7 self-clear", p);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame(8'h04, 6, 8'hDE, 1'b0, "R7 mid-frame request", p);
    run_frame(8'h05, 6, 8'h21, 1'b0, "R7 cleared again", p);
    prev = p;
  endtask

  task automatic t_hold();
    src = 2'd3; hold = 1'b1;
    run_frame(8'h6B, 7, ~prev, 1'b0, "R8 R9 hold on calc", p);
    prev = p;
    run_frame(8'h70, 8, ~prev, 1'b0, "R8 hold persists", p);
    prev = p;
    hold = 1'b0;
    run_frame(8'h1F, 5, prev, 1'b0, "R8 hold released", p);
    prev = p;
  endtask

  task automatic t_both();
    src = 2'd2; ovh = 8'h5E;
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    hold = 1'b1;
    run_frame(8'h33, 5, 8'hA1, 1'b0, "R12 single inversion", p);
    hold = 1'b0;
    run_frame(8'h34, 5, 8'h5E, 1'b0, "R12 request consumed", p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_calc();
    t_sources();
    t_once();
    t_hold();
    t_both();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule